// File: doc/BRIEF.md
# AHB-Lite Transfer Sequence Checker

A passive monitor that sits on an AHB-Lite bus and watches the transfer type, burst kind, transfer size, direction, address and the bus-level ready signal on every clock. It drives nothing back onto the bus. When the master breaks a sequencing rule, the checker sets one of six sticky violation flags and records which kind of rule was broken first. Typical uses are a bring-up probe next to a master, or a permanent on-chip watchdog whose flags are sampled by some other agent.

A cycle counts as an accepted transfer only when the ready signal is high. On those cycles the checker keeps track of whether a burst is open and what control values it carries. For fixed-length bursts it also counts how many beats are still due, and for incrementing bursts it keeps the last beat address. A separate path checks that a pending address phase stays unchanged while ready is low. A one-cycle clear pulse empties the flags and the first-violation code.

Top module: `ahbseq_checker`

## Requirements
- R1: After a synchronous active-low reset, `viol` is all zero and `first_code` is 0. Transfer encodings are 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ. Burst encodings are 0 SINGLE, 1 INCR, 2/3 four-beat wrap/incr, 4/5 eight-beat wrap/incr, 6/7 sixteen-beat wrap/incr.
- R2: An accepted BUSY while no burst is open (after reset, after an accepted IDLE or after a SINGLE NONSEQ) sets `viol[0]`.
- R3: An accepted SEQ while no burst is open sets `viol[1]`. This covers SEQ directly after IDLE, SEQ as the first transfer after reset, and SEQ after a SINGLE NONSEQ.
- R4: For a fixed-length burst, the number of accepted SEQ beats after the NONSEQ must be the length minus one. An accepted IDLE or NONSEQ that arrives early, or one SEQ too many, sets `viol[2]`. BUSY cycles are not counted, and INCR bursts have no length check.
- R5: An accepted SEQ or BUSY inside an open burst whose write, size or burst value differs from the value captured at the NONSEQ sets `viol[3]`.
- R6: If a cycle with ready low carries NONSEQ or SEQ, and the next cycle carries a different transfer type or a different address, `viol[4]` is set.
- R7: In an incrementing burst (INCR, or a four/eight/sixteen-beat incrementing burst), an accepted SEQ whose address is not the previous beat address plus 2^size sets `viol[5]`. Addresses in wrapping bursts are not checked.
- R8: Cycles with ready low are never taken as transfers. Legal traffic with wait states, BUSY cycles and wrapping bursts sets no flag.
- R9: Flags are sticky. Only `clr` clears them, and it also clears `first_code`. An event in the same cycle as `clr` is dropped.
- R10: `first_code` holds index+1 of the flag that set first and stays unchanged until `clr`. If several flags set in the same cycle, the lowest index is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Clears flags and code |
| htrans | input | 2 | Observed transfer type |
| hburst | input | 3 | Observed burst kind |
| hsize | input | 3 | Observed transfer size (log2 bytes) |
| hwrite | input | 1 | Observed direction |
| haddr | input | ADDR_W | Observed address |
| hready | input | 1 | Bus-level ready; high marks an accepted transfer |
| viol | output | 6 | Sticky violation flags, bit index per R2–R7 |
| first_code | output | 3 | Index+1 of the first flag set, 0 when none |

## Verification
The bench builds the checker with `ADDR_W` = 16. Addresses keep the same arithmetic as the 32-bit default and stay short enough to read. That width is enough to reach every corner: beats that are short or one too many, BUSY cycles inside counted bursts, wrap-around addresses that must not be flagged, address or type changes during wait states, two flags raised in one cycle, and a clear that lands on the same cycle as an event.

// File: rtl/ahbseq_pkg.sv
// Package: shared constants and helpers for the transfer sequence checker.
// Assumes the standard AHB-Lite transfer and burst encodings.
package ahbseq_pkg;
    localparam int NUM_V  = 6;
    localparam int CODE_W = 3;
    localparam int BEAT_W = 4;

    localparam logic [1:0] TR_IDLE = 2'd0;
    localparam logic [1:0] TR_BUSY = 2'd1;
    localparam logic [1:0] TR_NSEQ = 2'd2;
    localparam logic [1:0] TR_SEQ  = 2'd3;

    localparam int V_BUSY = 0;
    localparam int V_SEQ  = 1;
    localparam int V_CNT  = 2;
    localparam int V_CTRL = 3;
    localparam int V_HOLD = 4;
    localparam int V_ADDR = 5;

    // Number of SEQ beats that follow the NONSEQ of a fixed-length burst.
    function automatic logic [BEAT_W-1:0] seq_beats(input logic [2:0] b);
        case (b)
            3'd2, 3'd3: seq_beats = BEAT_W'(3);
            3'd4, 3'd5: seq_beats = BEAT_W'(7);
            3'd6, 3'd7: seq_beats = BEAT_W'(15);
            default:    seq_beats = '0;
        endcase
    endfunction

    // True for the wrapping burst kinds.
    function automatic logic is_wrap(input logic [2:0] b);
        is_wrap = (b == 3'd2) || (b == 3'd4) || (b == 3'd6);
    endfunction
endpackage

// File: rtl/ahbseq_tracker.sv
// Module: ahbseq_tracker
// Follows burst progress on accepted cycles (hready high) and reports
// one-cycle events for BUSY/SEQ outside a burst, beat count errors,
// control changes and incrementing address errors.
// Assumes hready is the bus-level ready seen by every slave.
module ahbseq_tracker
    import ahbseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hburst,
    input  logic [2:0]        hsize,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hready,
    output logic [NUM_V-1:0]  ev
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              open_q, open_d;
    logic              fixed_q, fixed_d;
    logic [BEAT_W-1:0] left_q, left_d;
    logic              wr_q, wr_d;
    logic [2:0]        sz_q, sz_d;
    logic [2:0]        bu_q, bu_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              ctrl_diff;
    logic              due;
    logic [ADDR_W-1:0] next_addr;

    assign ctrl_diff = (hwrite != wr_q) || (hsize != sz_q) || (hburst != bu_q);
    assign due       = open_q && fixed_q && (left_q != '0);
    assign next_addr = addr_q + (ONE << hsize);

    // Decide events and next burst state for the accepted transfer.
    always_comb begin
        ev      = '0;
        open_d  = open_q;
        fixed_d = fixed_q;
        left_d  = left_q;
        wr_d    = wr_q;
        sz_d    = sz_q;
        bu_d    = bu_q;
        addr_d  = addr_q;
        if (hready) begin
            case (htrans)
                TR_IDLE: begin
                    if (due) ev[V_CNT] = 1'b1;
                    open_d = 1'b0;
                end
                TR_BUSY: begin
                    if (!open_q)        ev[V_BUSY] = 1'b1;
                    else if (ctrl_diff) ev[V_CTRL] = 1'b1;
                end
                TR_NSEQ: begin
                    if (due) ev[V_CNT] = 1'b1;
                    open_d  = (hburst != 3'd0);
                    fixed_d = (hburst >= 3'd2);
                    left_d  = seq_beats(hburst);
                    wr_d    = hwrite;
                    sz_d    = hsize;
                    bu_d    = hburst;
                    addr_d  = haddr;
                end
                default: begin
                    if (!open_q) begin
                        ev[V_SEQ] = 1'b1;
                    end else begin
                        if (ctrl_diff) ev[V_CTRL] = 1'b1;
                        if (fixed_q) begin
                            if (left_q == '0) ev[V_CNT] = 1'b1;
                            else              left_d = left_q - 1'b1;
                        end
                        if (!is_wrap(bu_q) && (haddr != next_addr))
                            ev[V_ADDR] = 1'b1;
                        addr_d = haddr;
                    end
                end
            endcase
        end
    end

    // Burst state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            fixed_q <= 1'b0;
            left_q  <= '0;
            wr_q    <= 1'b0;
            sz_q    <= '0;
            bu_q    <= '0;
            addr_q  <= '0;
        end else begin
            open_q  <= open_d;
            fixed_q <= fixed_d;
            left_q  <= left_d;
            wr_q    <= wr_d;
            sz_q    <= sz_d;
            bu_q    <= bu_d;
            addr_q  <= addr_d;
        end
    end
endmodule

// File: rtl/ahbseq_hold.sv
// Module: ahbseq_hold
// Flags a pending NONSEQ/SEQ address phase that changes type or address
// in the cycle after one where hready was low.
// Assumes hready low means the current address phase is being extended.
module ahbseq_hold
    import ahbseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        htrans,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hready,
    output logic              ev_hold
);
    logic              pend_q;
    logic [1:0]        tr_q;
    logic [ADDR_W-1:0] ad_q;

    assign ev_hold = pend_q && ((htrans != tr_q) || (haddr != ad_q));

    // Remember a stalled active address phase for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            tr_q   <= TR_IDLE;
            ad_q   <= '0;
        end else begin
            pend_q <= !hready && htrans[1];
            tr_q   <= htrans;
            ad_q   <= haddr;
        end
    end
endmodule

// File: rtl/ahbseq_log.sv
// Module: ahbseq_log
// Turns one-cycle events into sticky flags and stores the code of the
// first one. A clear pulse wins over events in the same cycle.
module ahbseq_log #(
    parameter int NV = 6,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [NV-1:0] ev,
    output logic [NV-1:0] flags,
    output logic [CW-1:0] code
);
    logic [CW-1:0] pick;

    // One sticky bit per event kind.
    for (genvar i = 0; i < NV; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n || clr) flags[i] <= 1'b0;
            else if (ev[i])    flags[i] <= 1'b1;
        end
    end

    // Lowest-index event present this cycle, as index+1.
    always_comb begin
        pick = '0;
        for (int i = NV - 1; i >= 0; i--)
            if (ev[i]) pick = CW'(i + 1);
    end

    // Latch the first code until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)               code <= '0;
        else if (code == '0 && ev != '0) code <= pick;
    end
endmodule

// File: rtl/ahbseq_checker.sv
// Module: ahbseq_checker (top)
// Passive AHB-Lite transfer sequence monitor. Combines the burst tracker,
// the wait-state hold check and the sticky flag log.
// Assumes all inputs are synchronous to clk.
module ahbseq_checker
    import ahbseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hburst,
    input  logic [2:0]        hsize,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              hready,
    output logic [NUM_V-1:0]  viol,
    output logic [CODE_W-1:0] first_code
);
    logic [NUM_V-1:0] trk_ev;
    logic             hold_ev;
    logic [NUM_V-1:0] all_ev;

    ahbseq_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst),
        .hsize(hsize), .hwrite(hwrite), .haddr(haddr), .hready(hready),
        .ev(trk_ev)
    );

    ahbseq_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .htrans(htrans), .haddr(haddr),
        .hready(hready), .ev_hold(hold_ev)
    );

    // Merge the wait-state event into its flag position.
    always_comb begin
        all_ev         = trk_ev;
        all_ev[V_HOLD] = hold_ev;
    end

    ahbseq_log #(.NV(NUM_V), .CW(CODE_W)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ev(all_ev),
        .flags(viol), .code(first_code)
    );
endmodule

// File: rtl/ahbseq_checker_sva.sv
// Module: ahbseq_checker_sva
// Assertions on the checker's ports, attached by bind.
module ahbseq_checker_sva
    import ahbseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic [1:0]        htrans,
    input logic [ADDR_W-1:0] haddr,
    input logic              hready,
    input logic [NUM_V-1:0]  viol,
    input logic [CODE_W-1:0] first_code
);
    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (viol == '0 && first_code == '0));

    a_r2_busy_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && htrans == TR_IDLE && !clr) ##1 (hready && htrans == TR_BUSY && !clr)
        |=> viol[V_BUSY]);

    a_r3_seq_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && htrans == TR_IDLE && !clr) ##1 (hready && htrans == TR_SEQ && !clr)
        |=> viol[V_SEQ]);

    a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready && htrans[1] && !clr) ##1 (haddr != $past(haddr) && !clr)
        |=> viol[V_HOLD]);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((viol & $past(viol)) == $past(viol)));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (viol == '0 && first_code == '0));

    a_r10_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (first_code != '0 && !clr) |=> first_code == $past(first_code));

    a_r10_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (first_code != '0) |-> viol[first_code - 3'd1]);
endmodule

bind ahbseq_checker ahbseq_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .clr(clr), .htrans(htrans), .haddr(haddr),
    .hready(hready), .viol(viol), .first_code(first_code)
);

// File: tb/ahbseq_checker_test.sv
// Scoreboard bench: driver tasks queue expected flag states per cycle,
// a negedge monitor pops and compares them.
module ahbseq_checker_test;
    localparam int AW = 16;
    localparam logic [1:0] IDL = 2'd0, BSY = 2'd1, NSQ = 2'd2, SQ = 2'd3;

    typedef struct {
        int         cyc;
        logic [5:0] v;
        logic [2:0] c;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic [1:0]    htrans = IDL;
    logic [2:0]    hburst = '0;
    logic [2:0]    hsize = '0;
    logic          hwrite = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic          hready = 1'b1;
    logic [5:0]    viol;
    logic [2:0]    first_code;

    int   cyc = 0;
    int   n_run = 0;
    int   n_fail = 0;
    exp_t q[$];

    ahbseq_checker #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .htrans(htrans), .hburst(hburst),
        .hsize(hsize), .hwrite(hwrite), .haddr(haddr), .hready(hready),
        .viol(viol), .first_code(first_code)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    // Monitor: compare queued expectations due after this edge.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (viol !== e.v || first_code !== e.c) begin
                n_fail++;
                $display("FAIL %s: viol=%b code=%0d expected viol=%b code=%0d",
                         e.tag, viol, first_code, e.v, e.c);
            end
        end
    end

    task automatic drive(input logic [1:0] t, input logic [2:0] b, input logic [2:0] s,
                         input logic w, input logic [AW-1:0] a, input logic r,
                         input logic c);
        @(posedge clk);
        #1;
        htrans = t; hburst = b; hsize = s; hwrite = w; haddr = a; hready = r; clr = c;
    endtask

    // Expect state after the edge that captures the inputs just driven.
    task automatic expect_st(input logic [5:0] v, input logic [2:0] c, input string tag);
        exp_t e;
        e.cyc = cyc + 1; e.v = v; e.c = c; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        drive(IDL, 3'd0, 3'd0, 1'b0, '0, 1'b1, 1'b0);
    endtask

    task automatic clear_all();
        drive(IDL, 3'd0, 3'd0, 1'b0, '0, 1'b1, 1'b1);
        expect_st(6'b0, 3'd0, "R9 clear");
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) idle();
        @(posedge clk); #1 rst_n = 1'b1;
        expect_st(6'b0, 3'd0, "R1 reset");
        idle(); expect_st(6'b0, 3'd0, "R1 first idle");

        // R8 legal four-beat incr with wait states and BUSY
        drive(NSQ, 3'd3, 3'd2, 1'b1, 16'h0100, 1'b0, 1'b0);
        drive(NSQ, 3'd3, 3'd2, 1'b1, 16'h0100, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd2, 1'b1, 16'h0104, 1'b1, 1'b0);
        drive(BSY, 3'd3, 3'd2, 1'b1, 16'h0108, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd2, 1'b1, 16'h0108, 1'b0, 1'b0);
        drive(SQ,  3'd3, 3'd2, 1'b1, 16'h0108, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd2, 1'b1, 16'h010C, 1'b1, 1'b0);
        idle(); expect_st(6'b0, 3'd0, "R8 legal incr4 with waits");

        // R8/R7 legal undefined-length incr, halfword
        drive(NSQ, 3'd1, 3'd1, 1'b0, 16'h0040, 1'b1, 1'b0);
        drive(SQ,  3'd1, 3'd1, 1'b0, 16'h0042, 1'b1, 1'b0);
        drive(SQ,  3'd1, 3'd1, 1'b0, 16'h0044, 1'b1, 1'b0);
        idle(); expect_st(6'b0, 3'd0, "R7 legal incr steps");

        // R2 BUSY after IDLE, then R9 sticky
        drive(BSY, 3'd1, 3'd0, 1'b0, 16'h0000, 1'b1, 1'b0);
        expect_st(6'b000001, 3'd1, "R2 busy after idle");
        idle(); expect_st(6'b000001, 3'd1, "R9 sticky");
        clear_all();

        // R3 SEQ after IDLE
        drive(SQ, 3'd1, 3'd2, 1'b0, 16'h0010, 1'b1, 1'b0);
        expect_st(6'b000010, 3'd2, "R3 seq after idle");
        clear_all();

        // R3 SEQ after SINGLE
        drive(NSQ, 3'd0, 3'd2, 1'b0, 16'h0020, 1'b1, 1'b0);
        drive(SQ,  3'd0, 3'd2, 1'b0, 16'h0024, 1'b1, 1'b0);
        expect_st(6'b000010, 3'd2, "R3 seq after single");
        clear_all();

        // R4 short four-beat burst
        drive(NSQ, 3'd3, 3'd2, 1'b0, 16'h0100, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd2, 1'b0, 16'h0104, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd2, 1'b0, 16'h0108, 1'b1, 1'b0);
        expect_st(6'b0, 3'd0, "R4 no early flag");
        idle(); expect_st(6'b000100, 3'd3, "R4 short burst");
        clear_all();

        // R4 long burst with BUSY not counted
        drive(NSQ, 3'd3, 3'd0, 1'b0, 16'h0000, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd0, 1'b0, 16'h0001, 1'b1, 1'b0);
        drive(BSY, 3'd3, 3'd0, 1'b0, 16'h0002, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd0, 1'b0, 16'h0002, 1'b1, 1'b0);
        drive(SQ,  3'd3, 3'd0, 1'b0, 16'h0003, 1'b1, 1'b0);
        expect_st(6'b0, 3'd0, "R4 busy not counted");
        drive(SQ,  3'd3, 3'd0, 1'b0, 16'h0004, 1'b1, 1'b0);
        expect_st(6'b000100, 3'd3, "R4 extra beat");
        clear_all();

        // R7/R4 legal wrapping burst
        drive(NSQ, 3'd2, 3'd2, 1'b1, 16'h0038, 1'b1, 1'b0);
        drive(SQ,  3'd2, 3'd2, 1'b1, 16'h003C, 1'b1, 1'b0);
        drive(SQ,  3'd2, 3'd2, 1'b1, 16'h0030, 1'b1, 1'b0);
        drive(SQ,  3'd2, 3'd2, 1'b1, 16'h0034, 1'b1, 1'b0);
        idle(); expect_st(6'b0, 3'd0, "R7 wrap not address checked");

        // R5 write change on SEQ
        drive(NSQ, 3'd5, 3'd2, 1'b1, 16'h0080, 1'b1, 1'b0);
        drive(SQ,  3'd5, 3'd2, 1'b0, 16'h0084, 1'b1, 1'b0);
        expect_st(6'b001000, 3'd4, "R5 write change");
        clear_all();

        // R5 size change on BUSY
        drive(NSQ, 3'd1, 3'd2, 1'b0, 16'h0080, 1'b1, 1'b0);
        drive(BSY, 3'd1, 3'd1, 1'b0, 16'h0084, 1'b1, 1'b0);
        expect_st(6'b001000, 3'd4, "R5 size change on busy");
        clear_all();

        // R6 address change during wait
        drive(NSQ, 3'd1, 3'd2, 1'b0, 16'h0300, 1'b0, 1'b0);
        drive(NSQ, 3'd1, 3'd2, 1'b0, 16'h0304, 1'b1, 1'b0);
        expect_st(6'b010000, 3'd5, "R6 address moved in wait");
        clear_all();

        // R6 type change during wait
        drive(NSQ, 3'd1, 3'd2, 1'b0, 16'h0300, 1'b0, 1'b0);
        drive(IDL, 3'd1, 3'd2, 1'b0, 16'h0300, 1'b1, 1'b0);
        expect_st(6'b010000, 3'd5, "R6 type changed in wait");
        clear_all();

        // R7 bad increment
        drive(NSQ, 3'd1, 3'd1, 1'b0, 16'h0200, 1'b1, 1'b0);
        drive(SQ,  3'd1, 3'd1, 1'b0, 16'h0203, 1'b1, 1'b0);
        expect_st(6'b100000, 3'd6, "R7 bad increment");
        clear_all();

        // R10 two flags in one cycle, lowest index wins
        drive(NSQ, 3'd1, 3'd2, 1'b1, 16'h0400, 1'b1, 1'b0);
        drive(SQ,  3'd1, 3'd2, 1'b0, 16'h040C, 1'b1, 1'b0);
        expect_st(6'b101000, 3'd4, "R10 same-cycle priority");
        clear_all();

        // R10 first code held after a later flag
        drive(SQ,  3'd1, 3'd2, 1'b0, 16'h0000, 1'b1, 1'b0);
        expect_st(6'b000010, 3'd2, "R10 first event");
        drive(BSY, 3'd1, 3'd2, 1'b0, 16'h0000, 1'b1, 1'b0);
        expect_st(6'b000011, 3'd2, "R10 code held");
        clear_all();

        // R9 clear wins over a same-cycle event
        drive(BSY, 3'd1, 3'd0, 1'b0, 16'h0000, 1'b1, 1'b1);
        expect_st(6'b0, 3'd0, "R9 clear priority");
        idle(); expect_st(6'b0, 3'd0, "R9 dropped event stays dropped");

        repeat (3) idle();
        @(posedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d expectations unchecked, expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule